// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block keeps a small set of binary lock flags that two processors, one on the left port and one on the right port of a shared memory, use to agree on who may touch a shared resource. A port claims a flag by writing a 0 to it. It then reads the flag back to learn whether the claim succeeded: 0 means "yours" and 1 means "not yours". The flags gate nothing in hardware. Software that honours them provides the lockout.

The flags have their own select per port, separate from the memory select. The memory select has only one use here: a port with both selects deasserted reports standby on a registered status output. When both ports claim the same free flag in the same cycle, the left port wins. The right port's claim is remembered as pending and is granted as soon as the owner lets go. A release written by a port that does not own the flag withdraws only that port's own pending claim.

Top module: `sem_flag_bank`

## Requirements
- R1: While reset is asserted and after it, every flag is free, and a read of any flag from either port returns 1; `l_standby` and `r_standby` are 0 during reset.
- R2: A flag access needs the port's `*_sem_sel_n` low. With `*_wr` high and `*_wdata` 0, the port requests the flag whose index is `*_addr` (0 to NUM_FLAGS-1). A free flag is granted in that same clock edge. After that, a read returns 0 to the owner and 1 to the other port.
- R3: No flag is ever held by both ports at once.
- R4: A read cycle (`*_sem_sel_n` low, `*_wr` low) updates `*_rdata` on the next edge to the flag state before that edge. In every other cycle `*_rdata` keeps its value.
- R5: `*_standby` is registered. After each edge it equals the AND of that port's `*_mem_sel_n` and `*_sem_sel_n` sampled at that edge.
- R6: If both ports request the same free flag in one cycle, the left port becomes owner and the right port's request stays pending.
- R7: A write of 1 by the owner frees the flag. If the other port has a pending request, that port becomes owner in the same edge.
- R8: A write of 1 from a port that does not own the flag clears only that port's pending request. The owner is unchanged.
- R9: A write with `*_sem_sel_n` high changes no flag, even when `*_mem_sel_n` is low.
- R10: Any operation on one flag leaves every other flag's owner and pending state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_mem_sel_n | input | 1 | Left memory select, active low (standby only) |
| l_sem_sel_n | input | 1 | Left flag select, active low |
| l_wr | input | 1 | Left write strobe |
| l_addr | input | ADDR_W | Left flag index |
| l_wdata | input | 1 | Left write bit: 0 request, 1 release |
| l_rdata | output | 1 | Left read bit: 0 when left owns the flag |
| l_standby | output | 1 | Left standby status |
| r_mem_sel_n | input | 1 | Right memory select, active low (standby only) |
| r_sem_sel_n | input | 1 | Right flag select, active low |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | ADDR_W | Right flag index |
| r_wdata | input | 1 | Right write bit: 0 request, 1 release |
| r_rdata | output | 1 | Right read bit: 0 when right owns the flag |
| r_standby | output | 1 | Right standby status |

## Verification
An owner or pending bit that is wrong stays hidden until some port reads that flag. The read shows it one edge later, as a 0 on the wrong side, or as two zeros at once. A lost pending bit shows up only after the owner releases, when the waiting port still reads 1. The bench therefore reads every flag from both ports after each stimulus cycle, so any divergence is caught within NUM_FLAGS cycles of the step that caused it.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
// Per-port decode: one-hot request/release strobes, read enable, registered standby.
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mem_sel_n,
  input  logic                 sem_sel_n,
  input  logic                 wr,
  input  logic                 wdata,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_FLAGS-1:0] req_vec,
  output logic [NUM_FLAGS-1:0] rel_vec,
  output logic                 rd_en,
  output logic                 standby
);
  logic wr_hit;

  assign wr_hit = !sem_sel_n && wr;
  assign rd_en  = !sem_sel_n && !wr;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
    logic sel;
    assign sel        = (addr == ADDR_W'(g));
    assign req_vec[g] = wr_hit && sel && !wdata;
    assign rel_vec[g] = wr_hit && sel && wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b0;
    else     standby <= mem_sel_n && sem_sel_n;
  end
endmodule

// File: rtl/sem_flag_cell.sv
// One flag: owner plus a pending request per port.
module sem_flag_cell
  import sem_flag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic hold_l,
  output logic hold_r,
  output logic pend_l,
  output logic pend_r
);
  owner_e owner_q, owner_n;
  logic   pl_q, pl_n, pr_q, pr_n;

  always_comb begin
    owner_n = owner_q;
    pl_n    = pl_q;
    pr_n    = pr_q;
    // releases: owner frees, non-owner withdraws only its own pending claim
    if (l_rel) begin
      if (owner_q == OWN_LEFT) owner_n = OWN_NONE;
      pl_n = 1'b0;
    end
    if (r_rel) begin
      if (owner_q == OWN_RIGHT) owner_n = OWN_NONE;
      pr_n = 1'b0;
    end
    // requests become pending unless already owned by the requester
    if (l_req && owner_q != OWN_LEFT)  pl_n = 1'b1;
    if (r_req && owner_q != OWN_RIGHT) pr_n = 1'b1;
    // grant a free flag; left has priority
    if (owner_n == OWN_NONE) begin
      if (pl_n) begin
        owner_n = OWN_LEFT;
        pl_n    = 1'b0;
      end else if (pr_n) begin
        owner_n = OWN_RIGHT;
        pr_n    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
      pl_q    <= 1'b0;
      pr_q    <= 1'b0;
    end else begin
      owner_q <= owner_n;
      pl_q    <= pl_n;
      pr_q    <= pr_n;
    end
  end

  assign hold_l = (owner_q == OWN_LEFT);
  assign hold_r = (owner_q == OWN_RIGHT);
  assign pend_l = pl_q;
  assign pend_r = pr_q;
endmodule

// File: rtl/sem_read_port.sv
// Registered read-back: 0 when this port owns the addressed flag.
module sem_read_port #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] hold_vec,
  output logic                 rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= 1'b1;
    else if (rd_en) rdata <= !hold_vec[addr];
  end
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter  int NUM_FLAGS = 8,
  localparam int ADDR_W    = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_mem_sel_n,
  input  logic              l_sem_sel_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wdata,
  output logic              l_rdata,
  output logic              l_standby,
  input  logic              r_mem_sel_n,
  input  logic              r_sem_sel_n,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wdata,
  output logic              r_rdata,
  output logic              r_standby
);
  logic [NUM_FLAGS-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
  logic [NUM_FLAGS-1:0] hold_l_vec, hold_r_vec, pend_l_vec, pend_r_vec;
  logic                 l_rd_en, r_rd_en;

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
    .clk(clk), .rst(rst), .mem_sel_n(l_mem_sel_n), .sem_sel_n(l_sem_sel_n),
    .wr(l_wr), .wdata(l_wdata), .addr(l_addr),
    .req_vec(l_req_vec), .rel_vec(l_rel_vec), .rd_en(l_rd_en), .standby(l_standby)
  );

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
    .clk(clk), .rst(rst), .mem_sel_n(r_mem_sel_n), .sem_sel_n(r_sem_sel_n),
    .wr(r_wr), .wdata(r_wdata), .addr(r_addr),
    .req_vec(r_req_vec), .rel_vec(r_rel_vec), .rd_en(r_rd_en), .standby(r_standby)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_req_vec[f]), .l_rel(l_rel_vec[f]),
      .r_req(r_req_vec[f]), .r_rel(r_rel_vec[f]),
      .hold_l(hold_l_vec[f]), .hold_r(hold_r_vec[f]),
      .pend_l(pend_l_vec[f]), .pend_r(pend_r_vec[f])
    );
  end

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd_en), .addr(l_addr),
    .hold_vec(hold_l_vec), .rdata(l_rdata)
  );

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd_en), .addr(r_addr),
    .hold_vec(hold_r_vec), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_flag_bank_chk.sv
module sem_flag_bank_chk #(
  parameter  int NUM_FLAGS = 8,
  localparam int AW        = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 l_mem_sel_n,
  input logic                 l_sem_sel_n,
  input logic                 l_wr,
  input logic [AW-1:0]        l_addr,
  input logic                 l_wdata,
  input logic                 l_rdata,
  input logic                 l_standby,
  input logic                 r_mem_sel_n,
  input logic                 r_sem_sel_n,
  input logic                 r_wr,
  input logic [AW-1:0]        r_addr,
  input logic                 r_wdata,
  input logic                 r_rdata,
  input logic                 r_standby,
  input logic [NUM_FLAGS-1:0] hold_l_vec,
  input logic [NUM_FLAGS-1:0] hold_r_vec,
  input logic [NUM_FLAGS-1:0] pend_l_vec,
  input logic [NUM_FLAGS-1:0] pend_r_vec
);
  logic l_write, r_write, l_req, r_req, l_rel, r_rel, same_addr;
  assign l_write   = !l_sem_sel_n && l_wr;
  assign r_write   = !r_sem_sel_n && r_wr;
  assign l_req     = l_write && !l_wdata;
  assign r_req     = r_write && !r_wdata;
  assign l_rel     = l_write && l_wdata;
  assign r_rel     = r_write && r_wdata;
  assign same_addr = (l_addr == r_addr);

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (rst)
    (hold_l_vec & hold_r_vec) == '0);

  assert_left_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!l_sem_sel_n && !l_wr) |=> (l_rdata == !$past(hold_l_vec[l_addr])));

  assert_right_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!r_sem_sel_n && !r_wr) |=> (r_rdata == !$past(hold_r_vec[r_addr])));

  assert_left_standby_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (l_standby == $past(l_mem_sel_n && l_sem_sel_n)));

  assert_right_standby_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (r_standby == $past(r_mem_sel_n && r_sem_sel_n)));

  assert_tie_left_R6: assert property (@(posedge clk) disable iff (rst)
    (l_req && r_req && same_addr && !hold_l_vec[l_addr] && !hold_r_vec[l_addr])
    |=> (hold_l_vec[$past(l_addr)] && pend_r_vec[$past(l_addr)]));

  assert_handoff_R7: assert property (@(posedge clk) disable iff (rst)
    (l_rel && hold_l_vec[l_addr] && pend_r_vec[l_addr] && !(r_write && same_addr))
    |=> hold_r_vec[$past(l_addr)]);

  assert_foreign_release_R8: assert property (@(posedge clk) disable iff (rst)
    (r_rel && hold_l_vec[r_addr] && !(l_write && same_addr))
    |=> (hold_l_vec[$past(r_addr)] && !pend_r_vec[$past(r_addr)]));

  assert_no_sem_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    (l_sem_sel_n && r_sem_sel_n) |=> ($stable(hold_l_vec) && $stable(hold_r_vec)));
endmodule

bind sem_flag_bank sem_flag_bank_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (.*);

// File: tb/sem_flag_bank_test.sv
module sem_flag_bank_test;
  localparam int NF = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       l_mem_sel_n, l_sem_sel_n, l_wr, l_wdata;
  logic       r_mem_sel_n, r_sem_sel_n, r_wr, r_wdata;
  logic [2:0] l_addr, r_addr;
  logic       l_rdata, l_standby, r_rdata, r_standby;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state: 0 free, 1 left, 2 right
  int own [NF];
  bit pl  [NF];
  bit pr  [NF];

  always #4 clk = ~clk;

  sem_flag_bank #(.NUM_FLAGS(NF)) uut (
    .clk(clk), .rst(rst),
    .l_mem_sel_n(l_mem_sel_n), .l_sem_sel_n(l_sem_sel_n), .l_wr(l_wr),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_standby(l_standby),
    .r_mem_sel_n(r_mem_sel_n), .r_sem_sel_n(r_sem_sel_n), .r_wr(r_wr),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_standby(r_standby)
  );

  task automatic chk(logic act, logic exp, string req, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    l_mem_sel_n = 1; l_sem_sel_n = 1; l_wr = 0; l_wdata = 1; l_addr = 0;
    r_mem_sel_n = 1; r_sem_sel_n = 1; r_wr = 0; r_wdata = 1; r_addr = 0;
  endtask

  // op codes: 0 idle, 1 request, 2 release, 3 memory-only write
  task automatic drive_l(int op, int a);
    l_addr = 3'(a);
    case (op)
      1: begin l_sem_sel_n = 0; l_wr = 1; l_wdata = 0; end
      2: begin l_sem_sel_n = 0; l_wr = 1; l_wdata = 1; end
      3: begin l_mem_sel_n = 0; l_wr = 1; l_wdata = 0; end
      default: ;
    endcase
  endtask

  task automatic drive_r(int op, int a);
    r_addr = 3'(a);
    case (op)
      1: begin r_sem_sel_n = 0; r_wr = 1; r_wdata = 0; end
      2: begin r_sem_sel_n = 0; r_wr = 1; r_wdata = 1; end
      3: begin r_mem_sel_n = 0; r_wr = 1; r_wdata = 0; end
      default: ;
    endcase
  endtask

  function automatic void model(int lop, int la, int rop, int ra);
    for (int i = 0; i < NF; i++) begin
      if (lop == 2 && la == i) begin if (own[i] == 1) own[i] = 0; pl[i] = 0; end
      if (rop == 2 && ra == i) begin if (own[i] == 2) own[i] = 0; pr[i] = 0; end
      if (lop == 1 && la == i && own[i] != 1) pl[i] = 1;
      if (rop == 1 && ra == i && own[i] != 2) pr[i] = 1;
      if (own[i] == 0) begin
        if (pl[i])      begin own[i] = 1; pl[i] = 0; end
        else if (pr[i]) begin own[i] = 2; pr[i] = 0; end
      end
    end
  endfunction

  task automatic op(int lop, int la, int rop, int ra);
    idle();
    drive_l(lop, la);
    drive_r(rop, ra);
    @(negedge clk);
    idle();
    model(lop, la, rop, ra);
  endtask

  // read one flag from both ports; check against explicit expectations
  task automatic rd(int a, logic el, logic er, string req);
    idle();
    l_sem_sel_n = 0; l_addr = 3'(a);
    r_sem_sel_n = 0; r_addr = 3'(a);
    @(negedge clk);
    idle();
    chk(l_rdata, el, req, $sformatf("left read flag %0d", a));
    chk(r_rdata, er, req, $sformatf("right read flag %0d", a));
  endtask

  task automatic rd_model_all();
    for (int a = 0; a < NF; a++) begin
      rd(a, (own[a] == 1) ? 1'b0 : 1'b1, (own[a] == 2) ? 1'b0 : 1'b1, "R2 R10");
      chk(l_rdata & r_rdata | (l_rdata ^ r_rdata), 1'b1, "R3", "two owners");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NF; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(l_rdata, 1'b1, "R1", "left rdata in reset");
    chk(r_rdata, 1'b1, "R1", "right rdata in reset");
    chk(l_standby, 1'b0, "R1", "left standby in reset");
    chk(r_standby, 1'b0, "R1", "right standby in reset");
    rst = 0;
    @(negedge clk);
    chk(l_standby, 1'b1, "R5", "left standby idle");
    chk(r_standby, 1'b1, "R5", "right standby idle");
    l_mem_sel_n = 0;
    @(negedge clk);
    chk(l_standby, 1'b0, "R5", "left standby mem select");
    chk(r_standby, 1'b1, "R5", "right standby unaffected");
    idle();
    r_sem_sel_n = 0; r_addr = 3'd1;
    @(negedge clk);
    chk(r_standby, 1'b0, "R5", "right standby sem select");
    chk(r_rdata, 1'b1, "R1", "right read free flag 1");
    idle();
    rd(6, 1'b1, 1'b1, "R1");

    // tie on a free flag
    op(1, 2, 1, 2);
    rd(2, 1'b0, 1'b1, "R6");
    // owner releases, pending right takes over
    op(2, 2, 0, 0);
    rd(2, 1'b1, 1'b0, "R7");
    // left requests (pending), then withdraws with a foreign release
    op(1, 2, 0, 0);
    rd(2, 1'b1, 1'b0, "R2");
    op(2, 2, 0, 0);
    rd(2, 1'b1, 1'b0, "R8");
    op(0, 0, 2, 2);
    rd(2, 1'b1, 1'b1, "R8");
    // memory-only writes do not touch flags
    op(3, 5, 3, 5);
    rd(5, 1'b1, 1'b1, "R9");
    // independent flags
    op(1, 0, 1, 7);
    rd(0, 1'b0, 1'b1, "R10");
    rd(7, 1'b1, 1'b0, "R10");
    rd(3, 1'b1, 1'b1, "R10");
    // read data holds when not reading
    rd(0, 1'b0, 1'b1, "R4");
    l_addr = 3'd3; l_wr = 0;
    @(negedge clk);
    chk(l_rdata, 1'b0, "R4", "left rdata held");
    chk(r_rdata, 1'b1, "R4", "right rdata held");
    rd(3, 1'b1, 1'b1, "R4");
    op(2, 0, 2, 7);
    rd_model_all();

    // pseudo-random sweep, biased to collisions on one flag
    lfsr = 16'hACE1;
    for (int s = 0; s < 350; s++) begin
      int lop, rop, la, ra;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lop = int'(lfsr[1:0]);
      rop = int'(lfsr[3:2]);
      la  = int'(lfsr[6:4]);
      ra  = lfsr[7] ? la : int'(lfsr[10:8]);
      op(lop, la, rop, ra);
      rd_model_all();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule